// File: doc/BRIEF.md
# Stack-Machine Arithmetic and Logic Unit

This block performs the data operations of a stack processor. Each cycle it may accept one operation together with the two topmost stack words: the top word and the word below it. One clock later it presents a single-word result and the condition flags. It also tells the stack controller how many words to remove and whether to place the result back on the stack. The supported operations are bitwise logic, single-position shifts and rotates, and two's-complement add, subtract and multiply. Three compare forms subtract without storing a result. They differ only in how many operands they consume.

A constant-mode input applies to the two-operand operations. When it is set, the lower word stays on the stack, so one value can be reused as a constant against a stream of incoming top words. The block also holds the 8-bit status register. That register contains the four condition flags, a 2-bit interrupt mask, and two reserved bits that always read as zero. The status register changes on an ALU operation or on a direct write. Nothing else changes it.

Top module: `stack_alu`

## Requirements
- R1: Operation codes on `op_code` are: 0 NOT, 1 AND, 2 OR, 3 XOR, 4 shift-left logical, 5 shift-right logical, 6 shift-left arithmetic, 7 shift-right arithmetic, 8 rotate-left, 9 rotate-right, 10 ADD, 11 SUB, 12 MUL, 13 compare-pop-both, 14 compare-pop-top, 15 compare-keep. An operation with `op_valid` high at a clock edge produces `res_valid` high for exactly the next cycle, with `result`, `pop_count`, `push_res` and the flags updated at that same edge. While no operation is accepted, `pop_count` and `push_res` are zero.
- R2: NOT inverts the top word. AND, OR and XOR combine the top word with the next word. All four clear C and V.
- R3: Shifts and rotates move the top word by one bit position. C receives the bit that leaves the word. The logical right shift fills with 0, the arithmetic right shift replicates the old MSB, both left shifts fill with 0, and rotates feed the departing bit into the vacated end.
- R4: For the two left shifts (codes 4 and 6), V is set when the old MSB differs from the new MSB. V is 0 for right shifts and rotates.
- R5: ADD returns next + top. SUB returns next − top. Both use two's complement. C is the carry out of next + top for ADD, and of next + ~top + 1 for SUB. V is set on signed overflow.
- R6: MUL returns the low WIDTH bits of the signed product and clears C and V.
- R7: AND, OR, XOR, ADD, SUB and MUL report `pop_count` 1 with constant mode set and 2 without it, and `push_res` 1 in both cases. NOT, shifts and rotates report `pop_count` 1 and `push_res` 1. Constant mode has no effect on those single-operand operations or on compares.
- R8: Compares compute next − top with SUB flags and report `push_res` 0. `pop_count` is 2 for code 13, 1 for code 14 and 0 for code 15. `result` shows the difference.
- R9: N equals the result MSB. Z is 1 exactly when every result bit is 0.
- R10: Status bit 0 is Z, bit 1 is V, bit 2 is C and bit 3 is N. Bits 5:4 hold the interrupt mask, and only a direct write changes them. Bits 7:6 always read 0.
- R11: A direct write (`sr_write`) loads bits 5:0 from `sr_wdata`. When a direct write and an operation are accepted at the same edge, the written value wins. With neither present, the status register holds its value.
- R12: Synchronous reset clears the status register, `result`, `res_valid`, `pop_count` and `push_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see R1) |
| const_mode | input | 1 | Keep the lower operand on the stack |
| top_word | input | WIDTH | Top-of-stack operand |
| next_word | input | WIDTH | Operand directly below the top |
| sr_write | input | 1 | Direct status-register write strobe |
| sr_wdata | input | 8 | Value for a direct status write |
| res_valid | output | 1 | Result and stack commands are valid |
| result | output | WIDTH | Operation result |
| pop_count | output | 2 | Words the stack controller removes |
| push_res | output | 1 | Stack controller pushes `result` |
| status | output | 8 | Status register |

## Verification
The bench targets the flag corners, and each one shows a specific defect. A sign-crossing add and a borrow-producing subtract show reversed subtract operands or a missing overflow term. A left shift whose top two bits differ catches V wired only to arithmetic operations. A right shift and a rotate that drop a 1 expose a C taken from the wrong end. Compare vectors at equality and below it catch a compare that pushes a result or pops the wrong count. Constant-mode vectors on two-operand and single-operand codes show a mode that is ignored or misapplied. A simultaneous write and operation, followed by a mask check after a plain add, catches flag updates that clobber the mask or override the direct write.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

  typedef enum logic [3:0] {
    OP_NOT  = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_SHLL = 4'd4,
    OP_SHRL = 4'd5,
    OP_SHLA = 4'd6,
    OP_SHRA = 4'd7,
    OP_ROTL = 4'd8,
    OP_ROTR = 4'd9,
    OP_ADD  = 4'd10,
    OP_SUB  = 4'd11,
    OP_MUL  = 4'd12,
    OP_CMP2 = 4'd13,
    OP_CMP1 = 4'd14,
    OP_CMP0 = 4'd15
  } alu_op_e;

  // bit order matches status[3:0]: N C V Z
  typedef struct packed {
    logic n;
    logic c;
    logic v;
    logic z;
  } alu_flags_t;

  localparam int SR_BITS  = 8;
  localparam int MASK_LSB = 4;

endpackage

// File: rtl/stack_alu_logic.sv
module stack_alu_logic
  import stack_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] top_w,
  input  logic [WIDTH-1:0] nxt_w,
  output logic [WIDTH-1:0] res,
  output logic             c_out,
  output logic             v_out
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res   = '0;
    c_out = 1'b0;
    v_out = 1'b0;
    unique case (op)
      OP_NOT: res = ~top_w;
      OP_AND: res = top_w & nxt_w;
      OP_OR:  res = top_w | nxt_w;
      OP_XOR: res = top_w ^ nxt_w;
      OP_SHLL, OP_SHLA: begin
        res   = {top_w[MSB-1:0], 1'b0};
        c_out = top_w[MSB];
        v_out = top_w[MSB] ^ top_w[MSB-1];
      end
      OP_SHRL: begin
        res   = {1'b0, top_w[MSB:1]};
        c_out = top_w[0];
      end
      OP_SHRA: begin
        res   = {top_w[MSB], top_w[MSB:1]};
        c_out = top_w[0];
      end
      OP_ROTL: begin
        res   = {top_w[MSB-1:0], top_w[MSB]};
        c_out = top_w[MSB];
      end
      OP_ROTR: begin
        res   = {top_w[0], top_w[MSB:1]};
        c_out = top_w[0];
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/stack_alu_arith.sv
module stack_alu_arith
  import stack_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] top_w,
  input  logic [WIDTH-1:0] nxt_w,
  output logic [WIDTH-1:0] res,
  output logic             c_out,
  output logic             v_out
);
  localparam int MSB = WIDTH - 1;

  logic             do_sub;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum_ext;
  logic [WIDTH-1:0] prod_lo;

  // compares share the subtract path
  assign do_sub  = (op == OP_SUB) || (op == OP_CMP2) ||
                   (op == OP_CMP1) || (op == OP_CMP0);
  assign addend  = do_sub ? ~top_w : top_w;
  assign sum_ext = {1'b0, nxt_w} + {1'b0, addend} + {{WIDTH{1'b0}}, do_sub};
  assign prod_lo = nxt_w * top_w;

  always_comb begin
    if (op == OP_MUL) begin
      res   = prod_lo;
      c_out = 1'b0;
      v_out = 1'b0;
    end else begin
      res   = sum_ext[MSB:0];
      c_out = sum_ext[WIDTH];
      v_out = (nxt_w[MSB] == addend[MSB]) && (sum_ext[MSB] != nxt_w[MSB]);
    end
  end

endmodule

// File: rtl/stack_alu_status.sv
module stack_alu_status
  import stack_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               flag_we,
  input  alu_flags_t         flags_in,
  input  logic               wr,
  input  logic [SR_BITS-1:0] wdata,
  output logic [SR_BITS-1:0] sr
);
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[SR_BITS-1:MASK_LSB+2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (wr) begin
      sr <= {2'b00, wdata[MASK_LSB+1:0]};
    end else if (flag_we) begin
      sr[3:0] <= flags_in;
    end
  end

  // R11: with no write and no operation the register holds
  a_r11_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!flag_we && !wr) |=> $stable(sr));

  // R11: a direct write takes precedence over a flag update
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr |=> (sr[MASK_LSB+1:0] == $past(wdata[MASK_LSB+1:0])));

  // R10: operations never touch the interrupt mask
  a_r10_mask_kept: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !wr) |=> (sr[MASK_LSB+1:MASK_LSB] == $past(sr[MASK_LSB+1:MASK_LSB])));

endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [3:0]         op_code,
  input  logic               const_mode,
  input  logic [WIDTH-1:0]   top_word,
  input  logic [WIDTH-1:0]   next_word,
  input  logic               sr_write,
  input  logic [SR_BITS-1:0] sr_wdata,
  output logic               res_valid,
  output logic [WIDTH-1:0]   result,
  output logic [1:0]         pop_count,
  output logic               push_res,
  output logic [SR_BITS-1:0] status
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] lu_res, ar_res, sel_res;
  logic             lu_c, lu_v, ar_c, ar_v;
  logic             arith_sel;
  alu_flags_t       nxt_flags;
  logic [1:0]       nxt_pop;
  logic             nxt_push;

  assign op        = alu_op_e'(op_code);
  assign arith_sel = op_code[3] & (op_code[2] | op_code[1]);

  stack_alu_logic #(.WIDTH(WIDTH)) logic_i (
    .op(op), .top_w(top_word), .nxt_w(next_word),
    .res(lu_res), .c_out(lu_c), .v_out(lu_v)
  );

  stack_alu_arith #(.WIDTH(WIDTH)) arith_i (
    .op(op), .top_w(top_word), .nxt_w(next_word),
    .res(ar_res), .c_out(ar_c), .v_out(ar_v)
  );

  always_comb begin
    sel_res     = arith_sel ? ar_res : lu_res;
    nxt_flags.n = sel_res[MSB];
    nxt_flags.z = (sel_res == '0);
    nxt_flags.c = arith_sel ? ar_c : lu_c;
    nxt_flags.v = arith_sel ? ar_v : lu_v;
  end

  always_comb begin
    unique case (op)
      OP_AND, OP_OR, OP_XOR, OP_ADD, OP_SUB, OP_MUL: begin
        nxt_pop  = const_mode ? 2'd1 : 2'd2;
        nxt_push = 1'b1;
      end
      OP_CMP2: begin nxt_pop = 2'd2; nxt_push = 1'b0; end
      OP_CMP1: begin nxt_pop = 2'd1; nxt_push = 1'b0; end
      OP_CMP0: begin nxt_pop = 2'd0; nxt_push = 1'b0; end
      default: begin nxt_pop = 2'd1; nxt_push = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
      pop_count <= 2'd0;
      push_res  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        result    <= sel_res;
        pop_count <= nxt_pop;
        push_res  <= nxt_push;
      end else begin
        pop_count <= 2'd0;
        push_res  <= 1'b0;
      end
    end
  end

  stack_alu_status status_i (
    .clk(clk), .rst(rst), .flag_we(op_valid), .flags_in(nxt_flags),
    .wr(sr_write), .wdata(sr_wdata), .sr(status)
  );

  // R1: an accepted operation yields exactly one valid cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);
  a_r1_idle_no_cmd: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && pop_count == 2'd0 && !push_res));

  // R8: compares never push
  a_r8_cmp_no_push: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[3] && op_code[2] && (op_code[1] | op_code[0])) |=> !push_res);

  // R9: Z and N in the status agree with the registered result
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sr_write) |=> (status[0] == (result == '0)));
  a_r9_neg_flag: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sr_write) |=> (status[3] == result[MSB]));

  // R7: never more than two words are removed
  a_r7_pop_bound: assert property (@(posedge clk) disable iff (rst)
    pop_count != 2'd3);

endmodule

// File: tb/stack_alu_tb_top.sv
`timescale 1ns/1ps
module stack_alu_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         op_valid;
  logic [3:0]   op_code;
  logic         const_mode;
  logic [W-1:0] top_word, next_word;
  logic         sr_write;
  logic [7:0]   sr_wdata;
  logic         res_valid;
  logic [W-1:0] result;
  logic [1:0]   pop_count;
  logic         push_res;
  logic [7:0]   status;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stack_alu #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .const_mode(const_mode), .top_word(top_word), .next_word(next_word),
    .sr_write(sr_write), .sr_wdata(sr_wdata), .res_valid(res_valid),
    .result(result), .pop_count(pop_count), .push_res(push_res), .status(status)
  );

  // {op, const, top, next, result, NCVZ, pop, push}
  localparam int VW = 60;
  localparam int NV = 21;
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {4'd0,  1'b0, 16'h00FF, 16'h0000, 16'hFF00, 4'b1000, 2'd1, 1'b1}, // R2 NOT
    {4'd1,  1'b0, 16'h0F0F, 16'h00FF, 16'h000F, 4'b0000, 2'd2, 1'b1}, // R2 AND
    {4'd1,  1'b1, 16'hF0F0, 16'h0F0F, 16'h0000, 4'b0001, 2'd1, 1'b1}, // R7 AND const
    {4'd2,  1'b0, 16'h1200, 16'h0034, 16'h1234, 4'b0000, 2'd2, 1'b1}, // R2 OR
    {4'd3,  1'b0, 16'hFFFF, 16'h8001, 16'h7FFE, 4'b0000, 2'd2, 1'b1}, // R2 XOR
    {4'd4,  1'b0, 16'h4001, 16'h0000, 16'h8002, 4'b1010, 2'd1, 1'b1}, // R4 SHLL V
    {4'd6,  1'b0, 16'h8000, 16'h0000, 16'h0000, 4'b0111, 2'd1, 1'b1}, // R4 SHLA C V Z
    {4'd5,  1'b0, 16'h8001, 16'h0000, 16'h4000, 4'b0100, 2'd1, 1'b1}, // R3 SHRL
    {4'd7,  1'b0, 16'h8001, 16'h0000, 16'hC000, 4'b1100, 2'd1, 1'b1}, // R3 SHRA
    {4'd8,  1'b0, 16'h8001, 16'h0000, 16'h0003, 4'b0100, 2'd1, 1'b1}, // R3 ROTL
    {4'd9,  1'b0, 16'h0001, 16'h0000, 16'h8000, 4'b1100, 2'd1, 1'b1}, // R3 ROTR
    {4'd10, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 4'b1010, 2'd2, 1'b1}, // R5 ADD overflow
    {4'd10, 1'b1, 16'h0001, 16'hFFFF, 16'h0000, 4'b0101, 2'd1, 1'b1}, // R5 R7 ADD const carry
    {4'd11, 1'b0, 16'h0007, 16'h0005, 16'hFFFE, 4'b1000, 2'd2, 1'b1}, // R5 SUB borrow
    {4'd11, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 4'b0110, 2'd2, 1'b1}, // R5 SUB overflow
    {4'd12, 1'b0, 16'h0100, 16'h0100, 16'h0000, 4'b0001, 2'd2, 1'b1}, // R6 MUL truncate
    {4'd12, 1'b1, 16'hFFFF, 16'h0003, 16'hFFFD, 4'b1000, 2'd1, 1'b1}, // R6 R7 MUL signed const
    {4'd13, 1'b0, 16'h0005, 16'h0005, 16'h0000, 4'b0101, 2'd2, 1'b0}, // R8 CMP pop both
    {4'd14, 1'b1, 16'h0005, 16'h0003, 16'hFFFE, 4'b1000, 2'd1, 1'b0}, // R8 CMP pop top
    {4'd15, 1'b0, 16'h0002, 16'h0007, 16'h0005, 4'b0100, 2'd0, 1'b0}, // R8 CMP keep
    {4'd0,  1'b1, 16'hFFFF, 16'h1234, 16'h0000, 4'b0001, 2'd1, 1'b1}  // R7 const ignored
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 1'b0; op_code = 4'd0; const_mode = 1'b0;
    top_word = '0; next_word = '0; sr_write = 1'b0; sr_wdata = 8'h00;
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic do_op(input logic [3:0] c, input logic cm,
                       input logic [W-1:0] t, input logic [W-1:0] n);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; const_mode = cm; top_word = t; next_word = n;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", {res_valid, result, pop_count, push_res, status},
                 {1'b0, 16'h0000, 2'd0, 1'b0, 8'h00});
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i][59:56], VECS[i][55], VECS[i][54:39], VECS[i][38:23]);
      check($sformatf("R1 vec%0d", i),
            {res_valid, result, status[3:0], pop_count, push_res},
            {1'b1, VECS[i][22:7], VECS[i][6:3], VECS[i][2:1], VECS[i][0]});
    end

    // R1: one idle cycle clears valid and stack commands
    @(negedge clk);
    check("R1 idle", {res_valid, pop_count, push_res}, {1'b0, 2'd0, 1'b0});

    // R10: direct write, reserved bits read zero
    sr_write = 1'b1; sr_wdata = 8'hFF;
    @(negedge clk);
    sr_write = 1'b0;
    check("R10 write", status, 8'h3F);

    // R11: no op, no write, status unchanged
    @(negedge clk);
    check("R11 hold", status, 8'h3F);

    // R11: write and operation together, write wins
    op_valid = 1'b1; op_code = 4'd10; top_word = 16'h0001; next_word = 16'h7FFF;
    sr_write = 1'b1; sr_wdata = 8'h21;
    @(negedge clk);
    op_valid = 1'b0; sr_write = 1'b0;
    check("R11 write wins", status, 8'h21);

    // R10: operation updates flags and keeps mask 2'b10
    do_op(4'd10, 1'b0, 16'h0001, 16'h7FFF);
    check("R10 mask kept", status, 8'h2A);

    // R12: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset", {res_valid, result, pop_count, push_res, status},
                       {1'b0, 16'h0000, 2'd0, 1'b0, 8'h00});

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule